// File: doc/BRIEF.md
# Interleaved Interrupt Status Controller

This block gathers single-cycle hardware event pulses into two 32-bit interrupt registers and drives one interrupt line toward a processor. Each interrupt source owns a group of three neighbouring bits in its register. The lowest bit of the group is the pending flag. The middle bit is a write-one-to-clear strobe. The top bit is the enable. Because all three sit in one word, software can read the pending state, clear what it has serviced and keep its enables in a single read followed by a single write.

Register 0 (address 0) collects nine link-side sources: transfer done, bad address, timeout, negative-acknowledge/defer, bad data count, bus NACK, bus defer, PLL loss of lock and channel error. Register 1 (address 1) collects four video-side sources: ready for video, idle pattern sent, end of frame and checksum updated. A synchronous soft-clear input wipes every pending flag at once. An asynchronous active-low reset returns the whole block to idle.

Top module: `ilv_irq_ctrl`

## Requirements
- R1: Source i of a register has its pending flag at bit 3*i, its clear strobe at bit 3*i+1 and its enable at bit 3*i+2. Register 0 (reg_addr=0) holds sources 0..8 on evt_a[8:0]. Register 1 (reg_addr=1) holds sources 0..3 on evt_b[3:0].
- R2: An event pulse sets the matching pending flag at the next clock edge. The flag stays set until software clears it or a soft clear occurs.
- R3: A write with a 1 at a clear-strobe position clears that pending flag at the write's clock edge. Clear strobes always read back as 0.
- R4: A write loads every enable of the addressed register from the enable positions of the write data. A write that carries clear strobes together with the full enable pattern clears the flags and leaves the enables on. Enables change only on writes to their own register.
- R5: Writing zero to a register turns off every enable in it and leaves its pending flags unchanged.
- R6: If an event and a clear strobe for the same source arrive in the same cycle, the flag stays set.
- R7: irq is a register. Its value is the OR, over both registers, of (pending AND enable) as it stood one cycle earlier.
- R8: A cycle with soft_clr high clears every pending flag in both registers at that edge. Events in that cycle are dropped, and enables are kept.
- R9: Pending flags cannot be set by software writes. Bits 27..31 of register 0 and bits 12..31 of register 1 read 0.
- R10: While rst_n is low, all flags and enables are 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of all pending flags |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 1 | Register select (0 or 1) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the addressed register |
| evt_a | input | 9 | Event pulses for register 0 sources |
| evt_b | input | 4 | Event pulses for register 1 sources |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that event inputs, the write strobe and soft_clr are clean synchronous signals that are never X once reset is released, and that writes arrive one at a time through the single port. The bench drives every input just after a falling edge and holds it for exactly one rising edge, so each pulse and each write is seen once. It reads back only after the following falling edge. Collision cases, where an event lands in the same cycle as a clear strobe or a soft clear, are built by raising both signals in the same half-cycle.

// File: rtl/ilv_irq_pkg.sv
package ilv_irq_pkg;
  localparam int DATA_W   = 32;
  localparam int GRP_W    = 3;
  localparam int ACK_OFS  = 1;
  localparam int MASK_OFS = 2;
  localparam int NSRC_A   = 9;
  localparam int NSRC_B   = 4;

  // Source ordering in register 0
  localparam int SA_XFER_DONE = 0;
  localparam int SA_BAD_ADDR  = 1;
  localparam int SA_TIMEOUT   = 2;
  localparam int SA_NAK_DEFER = 3;
  localparam int SA_BAD_COUNT = 4;
  localparam int SA_BUS_NACK  = 5;
  localparam int SA_BUS_DEFER = 6;
  localparam int SA_PLL_LOSS  = 7;
  localparam int SA_CHAN_ERR  = 8;

  // Source ordering in register 1
  localparam int SB_VID_READY = 0;
  localparam int SB_IDLE_SENT = 1;
  localparam int SB_FRAME_END = 2;
  localparam int SB_CRC_UPD   = 3;

  function automatic int stat_pos(input int idx);
    return GRP_W * idx;
  endfunction
endpackage

// File: rtl/ilv_irq_bank.sv
module ilv_irq_bank
  import ilv_irq_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             wr_sel,
  input  logic [W-1:0]     wdata,
  input  logic [N_SRC-1:0] evt,
  output logic [N_SRC-1:0] status,
  output logic [N_SRC-1:0] mask,
  output logic [W-1:0]     rdata
);
  localparam int TOP_BIT = GRP_W * N_SRC - 1;

  logic [N_SRC-1:0] stat_nxt;
  logic [N_SRC-1:0] mask_nxt;
  logic [N_SRC-1:0] ack_hit;
  logic             mask_en;

  assign mask_en = wr_sel;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      ack_hit[i]  = wr_sel & wdata[stat_pos(i) + ACK_OFS];
      mask_nxt[i] = wdata[stat_pos(i) + MASK_OFS];
      if (soft_clr)
        stat_nxt[i] = 1'b0;
      else
        stat_nxt[i] = evt[i] | (status[i] & ~ack_hit[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= stat_nxt;
      if (mask_en)
        mask <= mask_nxt;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_SRC; i++) begin
      rdata[stat_pos(i)]            = status[i];
      rdata[stat_pos(i) + MASK_OFS] = mask[i];
    end
  end

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_chk
      localparam int P = GRP_W * g;
      AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[g] && !soft_clr) |=> status[g]); // R2
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wdata[P + ACK_OFS] && !evt[g] && !soft_clr) |=> !status[g]); // R3
      AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(mask[g])); // R4
      AST_SOFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> !status[g]); // R8
      AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !evt[g] |=> !$rose(status[g])); // R9
    end
  endgenerate

  initial begin
    AST_FITS: assert (TOP_BIT < W); // R1
  end
endmodule

// File: rtl/ilv_irq_merge.sv
module ilv_irq_merge #(
  parameter int NA = 9,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NA-1:0] pend_a,
  input  logic [NB-1:0] pend_b,
  output logic          irq
);
  logic irq_nxt;
  logic irq_q;

  always_comb irq_nxt = (|pend_a) | (|pend_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_nxt;
  end

  assign irq = irq_q;
endmodule

// File: rtl/ilv_irq_ctrl.sv
module ilv_irq_ctrl
  import ilv_irq_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int NA = NSRC_A,
  parameter int NB = NSRC_B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          reg_we,
  input  logic          reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic [NA-1:0] evt_a,
  input  logic [NB-1:0] evt_b,
  output logic          irq
);
  logic          sel_a, sel_b;
  logic [NA-1:0] stat_a, mask_a;
  logic [NB-1:0] stat_b, mask_b;
  logic [W-1:0]  rd_a, rd_b;

  assign sel_a = reg_we & ~reg_addr;
  assign sel_b = reg_we &  reg_addr;

  ilv_irq_bank #(.N_SRC(NA), .W(W)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_sel(sel_a),
    .wdata(reg_wdata), .evt(evt_a), .status(stat_a), .mask(mask_a),
    .rdata(rd_a));

  ilv_irq_bank #(.N_SRC(NB), .W(W)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_sel(sel_b),
    .wdata(reg_wdata), .evt(evt_b), .status(stat_b), .mask(mask_b),
    .rdata(rd_b));

  ilv_irq_merge #(.NA(NA), .NB(NB)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .pend_a(stat_a & mask_a), .pend_b(stat_b & mask_b), .irq(irq));

  assign reg_rdata = reg_addr ? rd_b : rd_a;

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_a == '0 && mask_b == '0) |=> !irq); // R7
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_a == '0 && stat_b == '0) |=> !irq); // R7
endmodule

// File: tb/ilv_irq_ctrl_test.sv
`timescale 1ns/1ps
module ilv_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_clr;
  logic        reg_we;
  logic        reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [8:0]  evt_a;
  logic [3:0]  evt_b;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  ilv_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_a(evt_a), .evt_b(evt_b), .irq(irq));

  function automatic logic [31:0] en_pat(input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v[3*i+2] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] ack_bit(input int i);
    return 32'h1 << (3*i+1);
  endfunction

  function automatic logic [31:0] st_bit(input int i);
    return 32'h1 << (3*i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rst_n = 1'b0; soft_clr = 0; reg_we = 0; reg_addr = 0; reg_wdata = '0;
    evt_a = '0; evt_b = '0;
    repeat (3) @(negedge clk);
    rd(0, v); chk("R10 reg0", v, 32'h0);
    rd(1, v); chk("R10 reg1", v, 32'h0);
    chk("R10 irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_layout;
    logic [31:0] v;
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    rd(0, v); chk("R1 R9 reg0 layout", v, en_pat(9));
    rd(1, v); chk("R1 R9 reg1 layout", v, en_pat(4));
    @(negedge clk);
    chk("R9 no irq from writes", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_event_irq;
    logic [31:0] v;
    evt_a[3] = 1'b1;
    @(negedge clk);
    evt_a = '0;
    rd(0, v); chk("R2 flag set", v, en_pat(9) | st_bit(3));
    chk("R7 irq one cycle later", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R7 irq raised", {31'h0, irq}, 32'h1);
    rd(0, v); chk("R2 flag held", v, en_pat(9) | st_bit(3));
  endtask

  task automatic t_ack;
    logic [31:0] v;
    wr(0, ack_bit(3) | en_pat(9));
    rd(0, v); chk("R3 R4 clear keep enable", v, en_pat(9));
    @(negedge clk);
    chk("R7 irq drops", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    evt_b[2] = 1'b1;
    wr(1, ack_bit(2) | en_pat(4));
    evt_b = '0;
    rd(1, v); chk("R6 event beats clear", v, en_pat(4) | st_bit(2));
    wr(1, ack_bit(2) | en_pat(4));
    rd(1, v); chk("R3 later clear", v, en_pat(4));
  endtask

  task automatic t_zero_write;
    logic [31:0] v;
    evt_a[0] = 1'b1;
    @(negedge clk);
    evt_a = '0;
    wr(0, 32'h0);
    rd(0, v); chk("R5 zero disables, flag kept", v, st_bit(0));
    @(negedge clk);
    chk("R5 R7 irq off when disabled", {31'h0, irq}, 32'h0);
    wr(0, ack_bit(0) | en_pat(9));
    rd(0, v); chk("R4 restore enables", v, en_pat(9));
  endtask

  task automatic t_soft;
    logic [31:0] v;
    evt_a[8] = 1'b1; evt_b[0] = 1'b1;
    @(negedge clk);
    evt_a = '0; evt_b = '0;
    rd(0, v); chk("R2 reg0 top source", v, en_pat(9) | st_bit(8));
    soft_clr = 1'b1; evt_a[1] = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0; evt_a = '0;
    rd(0, v); chk("R8 reg0 cleared", v, en_pat(9));
    rd(1, v); chk("R8 reg1 cleared", v, en_pat(4));
    @(negedge clk);
    chk("R8 irq low", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_all;
    logic [31:0] v;
    logic [31:0] st = '0;
    logic [31:0] ak = '0;
    for (int i = 0; i < 9; i++) begin st |= st_bit(i); ak |= ack_bit(i); end
    evt_a = 9'h1FF;
    @(negedge clk);
    evt_a = '0;
    rd(0, v); chk("R1 R2 all sources", v, en_pat(9) | st);
    wr(0, ak | en_pat(9));
    rd(0, v); chk("R3 clear all", v, en_pat(9));
  endtask

  initial begin
    t_reset;
    t_layout;
    t_event_irq;
    t_ack;
    t_collision;
    t_zero_write;
    t_soft;
    t_all;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule